// File: doc/BRIEF.md
# Boot ROM and RAM Memory Map

This block is the memory side of a small byte-wide computer. One shared bidirectional data bus serves two stores. The first is a read-only boot table that overlays the bottom of the address space. The second is a RAM that spans the full address range. The address comes from an external latch. A read strobe and a write strobe, both active low, control each access.

The region is chosen from the top `SEL_W` address bits only. When all of those bits are zero, the boot table answers. Any other value selects the RAM. The boot table holds a pattern computed from the address, so the processor's first fetch after reset finds code at address zero with no loading step. A write that lands in the boot window still goes into the RAM array underneath. A read of that address always returns the boot table, so the stored byte can never be seen.

The full system uses `ADDR_W = 16`: the boot window is then 0x0000–0x0FFF and the RAM window is 0x1000–0xFFFF. Reads are combinational from the current address. Writes are captured on the rising clock edge.

Top module: `mem_map_top`

## Requirements
- R1: An address is in the boot window exactly when its top `SEL_W` bits are all zero. Every other address is in the RAM window. With the defaults, 0x0FF is the last boot address and 0x100 is the first RAM address.
- R2: A read in the boot window returns the low address byte XOR `ROM_KEY` (default 0xA5).
- R3: While `rd_ni` is high, the block does not drive `data_io`.
- R4: A RAM-window address with `wr_ni` low at a rising clock edge stores `data_io`. A later read of that address returns the stored byte.
- R5: A write into the boot window leaves the value read from that address unchanged.
- R6: When both strobes are low, the write takes effect and the block does not drive `data_io`.
- R7: While `rst_ni` is low, the block does not drive the bus and ignores writes.
- R8: Right after reset is released, a read of address 0 returns the boot byte `ROM_KEY`.
- R9: During a read, `data_io` follows a change of `addr_i` in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; RAM writes are taken on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; blocks bus drive and writes |
| addr_i | input | ADDR_W | Current address from the external latch |
| rd_ni | input | 1 | Active-low read strobe |
| wr_ni | input | 1 | Active-low write strobe |
| data_io | inout | DATA_W | Shared tri-state data bus |

## Verification
The bench builds the block with `ADDR_W = 12` and `SEL_W = 4`. This gives a 256-byte boot window under a 4096-byte space. Both edges of the region boundary, the top address and many random locations in each window can therefore be reached in a few hundred cycles. Bus release is observed by having the bench drive zero onto the bus while the block should be silent; any drive from the block would corrupt that value. With these sizes the decode and readback logic is the same as in the 16-bit build, and only the array depths shrink.

// File: rtl/mem_map_pkg.sv
package mem_map_pkg;
  typedef enum logic {
    REG_BOOT = 1'b0,
    REG_RAM  = 1'b1
  } region_e;
endpackage

// File: rtl/mem_region_decode.sv
module mem_region_decode
  import mem_map_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SEL_W  = 4,
  localparam int BOOT_AW = ADDR_W - SEL_W
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output region_e            region_o,
  output logic [BOOT_AW-1:0] boot_off_o
);
  // any set bit in the select field leaves the boot window
  assign region_o   = region_e'(|addr_i[ADDR_W-1 -: SEL_W]);
  assign boot_off_o = addr_i[BOOT_AW-1:0];
endmodule

// File: rtl/mem_boot_rom.sv
module mem_boot_rom #(
  parameter int              AW      = 8,
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] ROM_KEY = 8'hA5,
  localparam int             DEPTH   = 1 << AW
) (
  input  logic [AW-1:0]     addr_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign table_q[g] = DATA_W'(g) ^ ROM_KEY;
  end

  assign data_o = table_q[addr_i];
endmodule

// File: rtl/mem_ram.sv
module mem_ram #(
  parameter int AW     = 12,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mem_map_top.sv
module mem_map_top
  import mem_map_pkg::*;
#(
  parameter int                ADDR_W  = 12,
  parameter int                DATA_W  = 8,
  parameter int                SEL_W   = 4,
  parameter logic [DATA_W-1:0] ROM_KEY = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  inout  wire  [DATA_W-1:0] data_io
);
  localparam int BOOT_AW = ADDR_W - SEL_W;

  region_e            region;
  logic [BOOT_AW-1:0] boot_off;
  logic [DATA_W-1:0]  boot_data;
  logic [DATA_W-1:0]  ram_data;
  logic [DATA_W-1:0]  rd_data;
  logic               ram_we;
  logic               bus_drive;

  mem_region_decode #(
    .ADDR_W(ADDR_W),
    .SEL_W (SEL_W)
  ) i_decode (
    .addr_i    (addr_i),
    .region_o  (region),
    .boot_off_o(boot_off)
  );

  mem_boot_rom #(
    .AW     (BOOT_AW),
    .DATA_W (DATA_W),
    .ROM_KEY(ROM_KEY)
  ) i_boot (
    .addr_i(boot_off),
    .data_o(boot_data)
  );

  // full address: boot-window writes land in the shadow bytes
  mem_ram #(
    .AW    (ADDR_W),
    .DATA_W(DATA_W)
  ) i_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .addr_i (addr_i),
    .wdata_i(data_io),
    .rdata_o(ram_data)
  );

  assign ram_we    = rst_ni & ~wr_ni;
  // write strobe wins a clash so the bus never sees two drivers
  assign bus_drive = rst_ni & ~rd_ni & wr_ni;
  assign rd_data   = (region == REG_BOOT) ? boot_data : ram_data;
  assign data_io   = bus_drive ? rd_data : 'z;
endmodule

// File: rtl/mem_map_chk.sv
module mem_map_chk #(
  parameter int                ADDR_W  = 12,
  parameter int                DATA_W  = 8,
  parameter int                SEL_W   = 4,
  parameter logic [DATA_W-1:0] ROM_KEY = 8'hA5,
  localparam int               BOOT_AW = ADDR_W - SEL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic [DATA_W-1:0] data_io,
  input logic              drive_i
);
  logic in_boot;
  assign in_boot = (addr_i[ADDR_W-1 -: SEL_W] == '0);

  // R3
  rd_idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ni |-> !drive_i);

  // R6
  strobe_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ni && !wr_ni) |-> !drive_i);

  // R2
  boot_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_i && in_boot) |-> data_io == (DATA_W'(addr_i[BOOT_AW-1:0]) ^ ROM_KEY));

  // R4
  ram_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && !in_boot) |=>
      ((drive_i && addr_i == $past(addr_i)) -> data_io == $past(data_io)));

  // R9
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_i && $past(drive_i) && $stable(addr_i)) |-> $stable(data_io));
endmodule

bind mem_map_top mem_map_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .SEL_W  (SEL_W),
  .ROM_KEY(ROM_KEY)
) i_mem_map_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .rd_ni  (rd_ni),
  .wr_ni  (wr_ni),
  .data_io(data_io),
  .drive_i(bus_drive)
);

// File: tb/test_mem_map_top.sv
module test_mem_map_top;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 4;
  localparam logic [7:0] KEY = 8'hA5;
  localparam int BOOT_N = 1 << (ADDR_W - SEL_W);
  localparam int SPACE  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              rd_n = 1'b1;
  logic              wr_n = 1'b1;
  logic [7:0]        tb_drv = '0;
  logic              tb_en = 1'b0;
  wire  [7:0]        data_bus;

  assign data_bus = tb_en ? tb_drv : 'z;

  always #4 clk = ~clk;

  mem_map_top #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .ROM_KEY(KEY)
  ) i_mem_map_top (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .addr_i (addr),
    .rd_ni  (rd_n),
    .wr_ni  (wr_n),
    .data_io(data_bus)
  );

  typedef struct {
    logic [ADDR_W-1:0] a;
    logic [7:0]        exp;
    string             tag;
  } item_t;

  item_t sb_q[$];
  logic  mon_go = 1'b0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  function automatic logic [7:0] boot_byte(int a);
    return 8'(a) ^ KEY;
  endfunction

  function automatic void compare(string tag, int a, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, act, exp);
    end
  endfunction

  // monitor: pops one expected item per flagged cycle
  always @(negedge clk) begin
    if (mon_go) begin
      item_t it;
      it = sb_q.pop_front();
      compare(it.tag, int'(it.a), data_bus, it.exp);
    end
  end

  task automatic cycle(int a, bit rd_v, bit wr_v, bit den, logic [7:0] dv,
                       bit chk, logic [7:0] exp, string tag);
    @(posedge clk); #1;
    addr   = ADDR_W'(a);
    rd_n   = rd_v;
    wr_n   = wr_v;
    tb_en  = den;
    tb_drv = dv;
    if (chk) begin
      sb_q.push_back('{ADDR_W'(a), exp, tag});
      mon_go = 1'b1;
    end
    @(posedge clk); #1;
    mon_go = 1'b0;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    tb_en  = 1'b0;
  endtask

  task automatic wr(int a, logic [7:0] d);
    cycle(a, 1'b1, 1'b0, 1'b1, d, 1'b0, 8'h00, "");
  endtask

  task automatic rd(int a, logic [7:0] exp, string tag);
    cycle(a, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, exp, tag);
  endtask

  logic [7:0] model [int];
  int         alist [$];

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R7: in reset the bus stays released while a read is requested
    cycle(1, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 8'h00, "R7");
    @(posedge clk); #1 rst_n = 1'b1;

    // R8: boot vector right after reset
    rd(0, KEY, "R8");

    // R3: strobe idle, bench drives zero, must read zero
    cycle(3, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 8'h00, "R3");

    // R1/R5: boundary of the windows
    rd(BOOT_N - 1, boot_byte(BOOT_N - 1), "R1");
    wr(BOOT_N - 1, 8'h33);
    rd(BOOT_N - 1, boot_byte(BOOT_N - 1), "R5");
    wr(BOOT_N, 8'hC3);
    rd(BOOT_N, 8'hC3, "R1");
    wr(SPACE - 1, 8'h96);
    rd(SPACE - 1, 8'h96, "R4");

    // R6: clash, write wins and bus carries the bench value
    cycle(12'h200, 1'b0, 1'b0, 1'b1, 8'h5C, 1'b1, 8'h5C, "R6");
    rd(12'h200, 8'h5C, "R6");

    // R7: writes during reset are dropped
    wr(12'h500, 8'h11);
    @(posedge clk); #1 rst_n = 1'b0;
    wr(12'h500, 8'h22);
    @(posedge clk); #1 rst_n = 1'b1;
    rd(12'h500, 8'h11, "R7");

    // R9: address change during a held read, no clock edge in between
    @(posedge clk); #1;
    addr = 12'h010; rd_n = 1'b0;
    #1 compare("R9", 12'h010, data_bus, boot_byte(12'h010));
    addr = 12'h011;
    #1 compare("R9", 12'h011, data_bus, boot_byte(12'h011));
    addr = 12'h500;
    #1 compare("R9", 12'h500, data_bus, 8'h11);
    @(posedge clk); #1 rd_n = 1'b1;

    // random writes in both windows, then read all back
    for (int i = 0; i < 24; i++) begin
      int a;
      logic [7:0] d;
      a = (i % 4 == 0) ? int'($urandom_range(BOOT_N - 1, 0))
                       : int'($urandom_range(SPACE - 1, BOOT_N));
      d = 8'($urandom);
      wr(a, d);
      model[a] = d;
      alist.push_back(a);
    end
    foreach (alist[k]) begin
      int a;
      a = alist[k];
      if (a < BOOT_N) rd(a, boot_byte(a), "R5");
      else            rd(a, model[a], "R4");
    end

    // R2: sweep of boot bytes
    for (int a = 0; a < BOOT_N; a += 17) rd(a, boot_byte(a), "R2");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule